// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word of a small floating-point coprocessor. It keeps three kinds of state:
- the control bits that software may write,
- a three-bit rounding-mode code,
- five sticky exception flags that the arithmetic datapath raises with single-cycle pulses.

The datapath reads the decoded rounding mode from a dedicated output.

A CPU write stores the writable bits of the word. The same write reloads the sticky flags from the word's trap-enable field; it does not simply clear them. When the rounding code differs from the stored one, the write also decodes it again. A code outside the supported range raises a one-cycle error pulse, and the rounding mode in force stays as it was. A CPU read builds its result from the stored control bits, with the flags merged in at their own positions.

Top module: `fpu_csr`

## Requirements
- R1: After a synchronous active-high reset, `rd_data_o` reads 0, `rnd_mode_o` is 0 (nearest even) and `bad_rnd_o` is 0.
- R2: A write stores `wr_data_i` masked by `WR_MASK`. The default mask keeps bits 9:5 (trap enables) and bits 2:0 (rounding code). Every other stored bit reads back as 0.
- R3: `rd_data_o` is the stored masked word ORed with the sticky flags placed at bits 14:10. Flag bit order within the flag field, and within the trap-enable field, is: invalid = bit 0, divide-by-zero = 1, overflow = 2, underflow = 3, inexact = 4.
- R4: In a cycle without a write, each bit of `flag_set_i` ORs into the sticky flags. Set flags stay set, and the change is visible on the read port from the cycle after the pulse.
- R5: A write loads the sticky flags with bits 9:5 of the written word.
- R6: If a write and flag pulses arrive in the same cycle, the write wins: the flags equal the written trap-enable bits and the pulses are lost.
- R7: Rounding codes 0 to 3 map to the rounding modes as follows. `rnd_mode_o` shows the new code from the cycle after the write.

  | Code | Rounding mode |
  |------|---------------|
  | 0 | nearest even |
  | 1 | toward zero |
  | 2 | toward plus infinity |
  | 3 | toward minus infinity |

- R8: A write whose bits 2:0 equal the stored rounding code neither changes `rnd_mode_o` nor pulses `bad_rnd_o`.
- R9: A write that changes the rounding code to any of the values 4 to 7 has three effects:
  - `bad_rnd_o` goes high for the following cycle only, unless the next write is also an illegal change.
  - `rnd_mode_o` keeps its previous value.
  - The illegal code is still stored.
- R10: Without a write, the stored control bits and `rnd_mode_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 32 | CPU write data |
| flag_set_i | input | 5 | Exception pulses from the datapath |
| rd_data_o | output | 32 | CPU read data (stored bits merged with flags) |
| rnd_mode_o | output | 2 | Decoded rounding mode to the datapath |
| bad_rnd_o | output | 1 | One-cycle pulse after an unsupported rounding code is written |

## Verification
The assertions check several properties on every cycle:
- flags never drop without a write, and a write reloads them from the trap-enable bits;
- the stored word and the rounding mode hold while no write occurs;
- an error pulse only ever follows a write and leaves the mode unchanged;
- no read bit appears outside the writable and flag fields.

Other behaviours appear only in the bench's scenarios. These are the exact rounding-code mapping, the rule that decoding happens only when the code changes (rewriting an illegal code stays silent), and the loss of pulses that coincide with a write.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int unsigned FLAG_N  = 5;
    localparam int unsigned RND_W   = 3;
    localparam int unsigned RND_LO  = 0;
    localparam int unsigned TEN_LO  = 5;
    localparam int unsigned FLG_LO  = 10;

    typedef enum logic [1:0] {
        RM_NEAREST_EVEN = 2'd0,
        RM_TO_ZERO      = 2'd1,
        RM_TO_POS       = 2'd2,
        RM_TO_NEG       = 2'd3
    } rnd_mode_e;

    typedef logic [FLAG_N-1:0] exc_vec_t;
    typedef logic [RND_W-1:0]  rnd_code_t;

    typedef struct packed {
        logic      legal;
        rnd_mode_e mode;
    } rnd_dec_t;

    function automatic rnd_dec_t decode_rnd(input rnd_code_t code);
        rnd_dec_t d;
        d.legal = (code[2] == 1'b0);
        case (code[1:0])
            2'd0:    d.mode = RM_NEAREST_EVEN;
            2'd1:    d.mode = RM_TO_ZERO;
            2'd2:    d.mode = RM_TO_POS;
            default: d.mode = RM_TO_NEG;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fpcsr_ctl_reg.sv
module fpcsr_ctl_reg #(
    parameter int unsigned          WIDTH = 32,
    parameter logic [WIDTH-1:0]     MASK  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data & MASK;
    end

    // R10: stored control bits hold between writes
    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

    // R2: a write lands the masked word
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == ($past(wr_data) & MASK)));

endmodule

// File: rtl/fpcsr_flag_acc.sv
module fpcsr_flag_acc
    import fpcsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  exc_vec_t load_val,
    input  exc_vec_t set_pulse,
    output exc_vec_t flags
);

    always_ff @(posedge clk) begin
        if (rst)        flags <= '0;
        else if (wr_en) flags <= load_val;
        else            flags <= flags | set_pulse;
    end

    // R4: without a write no sticky flag is ever lost
    p_flags_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((flags & $past(flags)) == $past(flags)));

    // R5, R6: a write reloads from the trap-enable bits regardless of pulses
    p_flags_reload_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flags == $past(load_val)));

endmodule

// File: rtl/fpcsr_rnd_ctl.sv
module fpcsr_rnd_ctl
    import fpcsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  rnd_code_t new_code,
    input  rnd_code_t old_code,
    output rnd_mode_e mode,
    output logic      bad
);

    rnd_dec_t dec;
    logic     changed;

    always_comb begin
        dec     = decode_rnd(new_code);
        changed = wr_en && (new_code != old_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= RM_NEAREST_EVEN;
            bad  <= 1'b0;
        end else begin
            bad <= changed && !dec.legal;
            if (changed && dec.legal) mode <= dec.mode;
        end
    end

    // R9: error pulse only follows a write
    p_bad_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        bad |-> $past(wr_en));

    // R9: an illegal code leaves the mode untouched
    p_bad_keeps_mode_r9: assert property (@(posedge clk) disable iff (rst)
        bad |-> $stable(mode));

    // R10: mode holds without a write
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode));

endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
    import fpcsr_pkg::*;
#(
    parameter int unsigned          CSR_W   = 32,
    parameter logic [CSR_W-1:0]     WR_MASK = 32'h0000_03E7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [CSR_W-1:0] wr_data_i,
    input  logic [4:0]       flag_set_i,
    output logic [CSR_W-1:0] rd_data_o,
    output logic [1:0]       rnd_mode_o,
    output logic             bad_rnd_o
);

    localparam logic [CSR_W-1:0] FLAG_MASK =
        CSR_W'((1 << FLAG_N) - 1) << FLG_LO;

    logic [CSR_W-1:0] stored;
    exc_vec_t         flags;
    rnd_mode_e        mode;

    fpcsr_ctl_reg #(
        .WIDTH (CSR_W),
        .MASK  (WR_MASK)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .q       (stored)
    );

    fpcsr_flag_acc u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_i),
        .load_val  (wr_data_i[TEN_LO +: FLAG_N]),
        .set_pulse (flag_set_i),
        .flags     (flags)
    );

    fpcsr_rnd_ctl u_rnd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .new_code (wr_data_i[RND_LO +: RND_W]),
        .old_code (stored[RND_LO +: RND_W]),
        .mode     (mode),
        .bad      (bad_rnd_o)
    );

    always_comb begin
        rd_data_o  = (stored & WR_MASK) | (CSR_W'(flags) << FLG_LO);
        rnd_mode_o = mode;
    end

    // R3: the read never shows bits outside the writable and flag fields
    p_read_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o & ~(WR_MASK | FLAG_MASK)) == '0);

endmodule

// File: tb/sim_fpu_csr.sv
`timescale 1ns/1ps
module sim_fpu_csr;

    localparam logic [31:0] MASK = 32'h0000_03E7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  fset = '0;
    logic [31:0] rd_data;
    logic [1:0]  rnd_mode;
    logic        bad_rnd;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] m_stored = '0;
    logic [4:0]  m_flags  = '0;
    logic [1:0]  m_mode   = '0;
    logic        m_bad    = 1'b0;

    always #10 clk = ~clk;

    fpu_csr u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .flag_set_i (fset),
        .rd_data_o  (rd_data),
        .rnd_mode_o (rnd_mode),
        .bad_rnd_o  (bad_rnd)
    );

    function automatic logic [31:0] exp_read(input logic [31:0] st, input logic [4:0] fl);
        return (st & MASK) | ({27'd0, fl} << 10);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic we, input logic [31:0] d, input logic [4:0] s);
        if (we) begin
            if (d[2:0] != m_stored[2:0]) begin
                m_bad = d[2];
                if (!d[2]) m_mode = d[1:0];
            end else begin
                m_bad = 1'b0;
            end
            m_stored = d & MASK;
            m_flags  = d[9:5];
        end else begin
            m_bad   = 1'b0;
            m_flags = m_flags | s;
        end
    endtask

    task automatic step(input string tag, input logic we,
                        input logic [31:0] d, input logic [4:0] s);
        wr_en   = we;
        wr_data = d;
        fset    = s;
        @(posedge clk);
        model_edge(we, d, s);
        @(negedge clk);
        check(tag, "read", rd_data, exp_read(m_stored, m_flags));
        check(tag, "mode", {30'd0, rnd_mode}, {30'd0, m_mode});
        check(tag, "bad",  {31'd0, bad_rnd}, {31'd0, m_bad});
        wr_en = 1'b0;
        fset  = '0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "read", rd_data, 32'h0);
        check("R1", "mode", {30'd0, rnd_mode}, 32'd0);
        check("R1", "bad",  {31'd0, bad_rnd}, 32'd0);

        step("R2_R5_R9", 1'b1, 32'hFFFF_FFFF, 5'd0);   // reads 0x7FE7, bad pulse
        step("R9_R10",   1'b0, 32'h0, 5'd0);           // pulse drops, state holds
        step("R7",       1'b1, 32'h0000_0002, 5'd0);   // toward +inf
        step("R4",       1'b0, 32'h0, 5'b00100);       // overflow flag
        step("R4",       1'b0, 32'h0, 5'b10001);       // invalid + inexact, sticky
        step("R3",       1'b0, 32'h0, 5'b00000);
        step("R6_R8",    1'b1, 32'h0000_0022, 5'b01000);
        step("R9",       1'b1, 32'h0000_0005, 5'd0);
        step("R8",       1'b1, 32'h0000_0005, 5'd0);   // same illegal code: silent
        step("R9",       1'b1, 32'h0000_0007, 5'd0);
        step("R7",       1'b1, 32'h0000_0003, 5'd0);
        step("R7",       1'b1, 32'h0000_0001, 5'd0);
        step("R7",       1'b1, 32'h0000_0000, 5'd0);
        step("R9",       1'b1, 32'h0000_0004, 5'd0);
        step("R5",       1'b1, 32'h0000_02A0, 5'd0);

        for (int i = 0; i < 400; i++) begin
            logic        we;
            logic [31:0] d;
            logic [4:0]  s;
            we = ($urandom % 4) == 0;
            d  = $urandom;
            s  = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
            step("R3", we, d, s);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule